// File: doc/BRIEF.md
# Receive Character Queue with Trigger, Timeout and Channel Routing

This block stores received characters in a 16-entry first-in first-out queue. A processor removes them one at a time through a data read strobe. The block reports the fill level, an empty flag, a full flag and a programmable trigger flag. It emits one-cycle event pulses for overrun and for a receive timeout, which fires after four character times without a new accepted character.

A two-bit channel mode selects where characters go:

- From the deserialiser, characters can enter the queue, go to the transmitter, or both.
- Processor data-register writes go either to the transmitter or back into the queue.

A detected line break enters the queue as a zero byte. Receive enable and disable inputs gate the queue, and a receive reset empties it. The deserialiser, the transmitter and interrupt masking are outside the block.

Top module: `rx_queue`

## Requirements
- R1: The queue holds up to 16 bytes and returns them in arrival order. level_o gives the current count, 0 to 16, and changes on the clock edge that accepts a push or a pop.
- R2: An arrival while the level is 16, with no accepted read in the same cycle, is discarded. overrun_o is then high for exactly the one cycle after that edge.
- R3: full_o rises when an accepted arrival brings the level to 16. It is cleared by any enabled read, including a read whose same-cycle arrival keeps the level at 16. A receive reset also clears it.
- R4: trig_o is high while the level is greater than or equal to the trigger register. A trig_wr_i pulse loads that register from trig_wdata_i, and reset sets it to 32.
- R5: When reads are enabled and the queue is not empty, rd_data_o shows the oldest byte; otherwise it shows 0. empty_o is high exactly when the level is 0. A read of an empty queue changes no state.
- R6: timeout_o pulses for one cycle 4*char_time_i cycles after the edge of the last accepted arrival, unless another accepted arrival comes first. Discarded arrivals do not restart the count, and a char_time_i of 0 disables the timeout.
- R7: chan_mode_i selects the routing:
  - 0 (normal): deserialiser characters enter the queue, and cpu_wr_i data goes to the transmitter.
  - 1 (echo): deserialiser characters enter the queue and are also forwarded to the transmitter.
  - 2 (local loopback): cpu_wr_i data enters the queue, the deserialiser is ignored, and nothing goes to the transmitter.
  - 3 (remote loopback): deserialiser characters go only to the transmitter.
- R8: Arrivals and reads have no effect unless rx_en_i is high and rx_dis_i is low.
- R9: rx_flush_i empties the queue, clears full_o, stops a pending timeout and wins over any same-cycle arrival or read.
- R10: In modes 0 and 1, brk_i pushes the byte 0x00. It takes precedence over a character arriving in the same cycle.
- R11: An accepted arrival and an accepted read in the same cycle leave the level unchanged and return the oldest byte. At level 16 such an arrival is accepted without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| rx_dis_i | input | 1 | Receive disable, overrides enable |
| rx_flush_i | input | 1 | Receive reset, empties the queue |
| chan_mode_i | input | 2 | Channel routing mode |
| char_valid_i | input | 1 | Deserialiser character strobe |
| char_data_i | input | 8 | Deserialiser character |
| brk_i | input | 1 | Break detected strobe |
| cpu_wr_i | input | 1 | Data register write strobe |
| cpu_wdata_i | input | 8 | Data register write value |
| cpu_rd_i | input | 1 | Data register read strobe |
| trig_wr_i | input | 1 | Trigger register write strobe |
| trig_wdata_i | input | 6 | Trigger register write value |
| char_time_i | input | 16 | Character time in clock cycles |
| rd_data_o | output | 8 | Oldest byte or 0 |
| level_o | output | 5 | Queue fill level |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Full flag |
| trig_o | output | 1 | Level at or above trigger |
| overrun_o | output | 1 | Overrun event pulse |
| timeout_o | output | 1 | Receive timeout event pulse |
| tx_valid_o | output | 1 | Character to transmitter strobe |
| tx_data_o | output | 8 | Character to transmitter |

## Verification
The assertions check on every cycle the invariants that relate the flags to one another:

- the level never exceeds 16;
- an overrun only follows a cycle at level 16;
- full implies level 16;
- an empty queue reads as zero;
- disabled or remote-loopback cycles leave the level alone;
- a receive reset empties the queue;
- timeout is a single-cycle pulse;
- local loopback never drives the transmitter.

Several behaviours need the bench's scenarios and its queue-based reference model:

- byte ordering;
- the exact cycle of the timeout;
- full being cleared by a read that coincides with an arrival;
- the trigger threshold after a register write;
- break bytes winning over a same-cycle character;
- the routing of each mode.

// File: rtl/rx_queue_pkg.sv
`timescale 1ns/1ps
package rx_queue_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chan_mode_e;
endpackage

// File: rtl/rx_queue_route.sv
`timescale 1ns/1ps
module rx_queue_route
  import rx_queue_pkg::*;
#(
  parameter int DW = 8
) (
  input  chan_mode_e        mode_i,
  input  logic              char_valid_i,
  input  logic [DW-1:0]     char_data_i,
  input  logic              brk_i,
  input  logic              cpu_wr_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  output logic              push_req_o,
  output logic [DW-1:0]     push_data_o,
  output logic              tx_valid_o,
  output logic [DW-1:0]     tx_data_o
);
  // line-side character, break forces a zero byte
  logic          line_req;
  logic [DW-1:0] line_data;

  assign line_req  = char_valid_i | brk_i;
  assign line_data = brk_i ? '0 : char_data_i;

  always_comb begin
    push_req_o  = 1'b0;
    push_data_o = line_data;
    tx_valid_o  = 1'b0;
    tx_data_o   = char_data_i;
    unique case (mode_i)
      CH_NORMAL: begin
        push_req_o = line_req;
        tx_valid_o = cpu_wr_i;
        tx_data_o  = cpu_wdata_i;
      end
      CH_ECHO: begin
        push_req_o = line_req;
        tx_valid_o = char_valid_i;
      end
      CH_LOCAL: begin
        push_req_o  = cpu_wr_i;
        push_data_o = cpu_wdata_i;
      end
      CH_REMOTE: begin
        tx_valid_o = char_valid_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rx_queue_store.sv
`timescale 1ns/1ps
module rx_queue_store #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [LW-1:0] level_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] cnt_q;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= adv(wr_q);
      if (pop_i)  rd_q <= adv(rd_q);
      unique case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign level_o = cnt_q;
endmodule

// File: rtl/rx_queue_timer.sv
`timescale 1ns/1ps
module rx_queue_timer #(
  parameter  int CT_W  = 16,
  localparam int LIM_W = CT_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            kick_i,
  input  logic [CT_W-1:0] char_time_i,
  output logic            fire_o
);
  logic [LIM_W-1:0] lim, cnt_q;
  logic             armed_q, fire_q;

  // four character times
  assign lim = {char_time_i, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else if (flush_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else if (kick_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      fire_q  <= 1'b0;
    end else if (armed_q && lim != '0 && cnt_q == lim - 1'b1) begin
      armed_q <= 1'b0;
      fire_q  <= 1'b1;
    end else begin
      fire_q <= 1'b0;
      if (armed_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/rx_queue.sv
`timescale 1ns/1ps
module rx_queue
  import rx_queue_pkg::*;
#(
  parameter  int DEPTH    = 16,
  parameter  int DW       = 8,
  parameter  int TRIG_W   = 6,
  parameter  int CT_W     = 16,
  parameter  int TRIG_RST = 32,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              rx_dis_i,
  input  logic              rx_flush_i,
  input  logic [1:0]        chan_mode_i,
  input  logic              char_valid_i,
  input  logic [DW-1:0]     char_data_i,
  input  logic              brk_i,
  input  logic              cpu_wr_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  input  logic              cpu_rd_i,
  input  logic              trig_wr_i,
  input  logic [TRIG_W-1:0] trig_wdata_i,
  input  logic [CT_W-1:0]   char_time_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              trig_o,
  output logic              overrun_o,
  output logic              timeout_o,
  output logic              tx_valid_o,
  output logic [DW-1:0]     tx_data_o
);
  logic              rx_ok, rd_en, pop_acc, push_acc, at_top;
  logic              push_req;
  logic [DW-1:0]     push_data, head;
  logic [LVL_W-1:0]  level;
  logic              full_q, ovr_q;
  logic [TRIG_W-1:0] trig_q;

  rx_queue_route #(.DW(DW)) u_route (
    .mode_i       (chan_mode_e'(chan_mode_i)),
    .char_valid_i (char_valid_i),
    .char_data_i  (char_data_i),
    .brk_i        (brk_i),
    .cpu_wr_i     (cpu_wr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .push_req_o   (push_req),
    .push_data_o  (push_data),
    .tx_valid_o   (tx_valid_o),
    .tx_data_o    (tx_data_o)
  );

  assign rx_ok    = rx_en_i & ~rx_dis_i;
  assign at_top   = (level == LVL_W'(DEPTH));
  assign rd_en    = rx_ok & cpu_rd_i & ~rx_flush_i;
  assign pop_acc  = rd_en & (level != '0);
  assign push_acc = rx_ok & push_req & ~rx_flush_i & (~at_top | pop_acc);

  rx_queue_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush_i),
    .push_i  (push_acc),
    .data_i  (push_data),
    .pop_i   (pop_acc),
    .head_o  (head),
    .level_o (level)
  );

  rx_queue_timer #(.CT_W(CT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (rx_flush_i),
    .kick_i      (push_acc),
    .char_time_i (char_time_i),
    .fire_o      (timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (rx_flush_i) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ovr_q <= rx_ok & push_req & ~push_acc;
      if (push_acc && !pop_acc && level == LVL_W'(DEPTH - 1)) full_q <= 1'b1;
      else if (rd_en)                                         full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        trig_q <= TRIG_W'(TRIG_RST);
    else if (trig_wr_i) trig_q <= trig_wdata_i;
  end

  assign rd_data_o = (rd_en || (rx_ok && !rx_flush_i)) && level != '0 ? head : '0;
  assign level_o   = level;
  assign empty_o   = (level == '0);
  assign full_o    = full_q;
  assign trig_o    = 32'(level) >= 32'(trig_q);
  assign overrun_o = ovr_q;
endmodule

// File: rtl/rx_queue_chk.sv
`timescale 1ns/1ps
module rx_queue_chk #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_en_i,
  input logic             rx_dis_i,
  input logic             rx_flush_i,
  input logic [1:0]       chan_mode_i,
  input logic             cpu_rd_i,
  input logic [DW-1:0]    rd_data_o,
  input logic [LVL_W-1:0] level_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             overrun_o,
  input logic             timeout_o,
  input logic             tx_valid_o
);
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(level_o) <= DEPTH); // R1

  AST_OVR_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> 32'($past(level_o)) == DEPTH); // R2

  AST_FULL_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> 32'(level_o) == DEPTH); // R3

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> rd_data_o == '0); // R5

  AST_TIMEOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R6

  AST_REMOTE_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_mode_i == 2'd3 && !cpu_rd_i && !rx_flush_i) |=> level_o == $past(level_o)); // R7

  AST_LOCAL_NO_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_mode_i == 2'd2 |-> !tx_valid_o); // R7

  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rx_en_i || rx_dis_i) && !rx_flush_i) |=> level_o == $past(level_o)); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_i |=> empty_o && !full_o); // R9
endmodule

bind rx_queue rx_queue_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_en_i     (rx_en_i),
  .rx_dis_i    (rx_dis_i),
  .rx_flush_i  (rx_flush_i),
  .chan_mode_i (chan_mode_i),
  .cpu_rd_i    (cpu_rd_i),
  .rd_data_o   (rd_data_o),
  .level_o     (level_o),
  .empty_o     (empty_o),
  .full_o      (full_o),
  .overrun_o   (overrun_o),
  .timeout_o   (timeout_o),
  .tx_valid_o  (tx_valid_o)
);

// File: tb/rx_queue_test.sv
`timescale 1ns/1ps
module rx_queue_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rx_en = 0, rx_dis = 0, flush = 0, char_valid = 0, brk = 0;
  logic       cpu_wr = 0, cpu_rd = 0, trig_wr = 0;
  logic [1:0] mode = 0;
  logic [7:0] char_data = 0, cpu_wdata = 0;
  logic [5:0] trig_wdata = 0;
  logic [15:0] char_time = 16'd3;
  logic [7:0] rd_data, tx_data;
  logic [4:0] level;
  logic       empty, full, trig, ovr, tmo, tx_valid;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  byte unsigned q[$];
  int full_m = 0, ovr_m = 0, tmo_m = 0, armed_m = 0, cnt_m = 0, trig_m = 32;

  always #4 clk = ~clk;

  rx_queue uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .rx_dis_i(rx_dis),
    .rx_flush_i(flush), .chan_mode_i(mode), .char_valid_i(char_valid),
    .char_data_i(char_data), .brk_i(brk), .cpu_wr_i(cpu_wr),
    .cpu_wdata_i(cpu_wdata), .cpu_rd_i(cpu_rd), .trig_wr_i(trig_wr),
    .trig_wdata_i(trig_wdata), .char_time_i(char_time), .rd_data_o(rd_data),
    .level_o(level), .empty_o(empty), .full_o(full), .trig_o(trig),
    .overrun_o(ovr), .timeout_o(tmo), .tx_valid_o(tx_valid), .tx_data_o(tx_data)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit ok_m();
    return rx_en && !rx_dis;
  endfunction

  task automatic cmp_comb();
    int exp_rd, txv, txd;
    exp_rd = (ok_m() && !flush && q.size() > 0) ? int'(q[0]) : 0;
    chk("R5 rd_data", rd_data, exp_rd);
    txv = ((mode == 0 && cpu_wr) || ((mode == 1 || mode == 3) && char_valid)) ? 1 : 0;
    txd = (mode == 0) ? int'(cpu_wdata) : int'(char_data);
    chk("R7 tx_valid", tx_valid, txv);
    if (txv == 1) chk("R7 tx_data", tx_data, txd);
  endtask

  task automatic model_step();
    bit preq, pop, push;
    byte unsigned pd;
    int old;
    preq = 0; pd = 0;
    if (mode == 0 || mode == 1) begin preq = char_valid || brk; pd = brk ? 8'h00 : char_data; end
    else if (mode == 2) begin preq = cpu_wr; pd = cpu_wdata; end
    if (trig_wr) trig_m = trig_wdata;
    if (flush) begin
      q.delete(); full_m = 0; ovr_m = 0; tmo_m = 0; armed_m = 0; cnt_m = 0;
      return;
    end
    old = q.size();
    pop = ok_m() && cpu_rd && old > 0;
    push = ok_m() && preq && (old < 16 || pop);
    ovr_m = (ok_m() && preq && !push) ? 1 : 0;
    if (pop) void'(q.pop_front());
    if (push) q.push_back(pd);
    if (push && !pop && old == 15) full_m = 1;
    else if (ok_m() && cpu_rd) full_m = 0;
    if (push) begin armed_m = 1; cnt_m = 0; tmo_m = 0; end
    else if (armed_m == 1 && char_time != 0 && cnt_m == 4 * int'(char_time) - 1) begin
      armed_m = 0; tmo_m = 1;
    end else begin
      tmo_m = 0;
      if (armed_m == 1) cnt_m++;
    end
  endtask

  task automatic cmp_state();
    chk("R1 level", level, q.size());
    chk("R5 empty", empty, q.size() == 0);
    chk("R3 full", full, full_m);
    chk("R4 trig", trig, q.size() >= trig_m);
    chk("R2 overrun", ovr, ovr_m);
    chk("R6 timeout", tmo, tmo_m);
  endtask

  task automatic cyc();
    #1 cmp_comb();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp_state();
  endtask

  task automatic push_ch(input logic [7:0] d);
    char_valid = 1; char_data = d; cyc(); char_valid = 0;
  endtask

  task automatic rd();
    cpu_rd = 1; cyc(); cpu_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lv, seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset level", level, 0);
    chk("R5 reset empty", empty, 1);
    chk("R3 reset full", full, 0);
    chk("R4 reset trig (32)", trig, 0);
    chk("R5 reset rd_data", rd_data, 0);

    rx_en = 1;
    // R1 ordering
    push_ch(8'hA1); push_ch(8'hA2); push_ch(8'hA3);
    chk("R1 head", rd_data, 8'hA1);
    rd(); chk("R1 second", rd_data, 8'hA2);
    rd(); rd();
    rd(); chk("R5 empty read", level, 0);

    // R2 R3 fill and overrun
    for (int i = 0; i < 16; i++) push_ch(8'(i + 16));
    chk("R3 full set", full, 1);
    push_ch(8'hEE);
    chk("R2 overrun pulse", ovr, 1);
    cyc();
    chk("R2 overrun ends", ovr, 0);

    // R11 at top
    char_valid = 1; char_data = 8'h77; cpu_rd = 1; cyc(); char_valid = 0; cpu_rd = 0;
    chk("R11 level kept", level, 16);
    chk("R11 no overrun", ovr, 0);
    chk("R3 full cleared by read", full, 0);
    for (int i = 0; i < 16; i++) rd();

    // R4 trigger
    trig_wr = 1; trig_wdata = 6'd3; cyc(); trig_wr = 0;
    push_ch(8'h01); push_ch(8'h02);
    chk("R4 below", trig, 0);
    push_ch(8'h03);
    chk("R4 reached", trig, 1);
    // R11 mid level
    char_valid = 1; char_data = 8'h04; cpu_rd = 1; cyc(); char_valid = 0; cpu_rd = 0;
    chk("R11 mid level", level, 3);
    rd();
    chk("R4 fell", trig, 0);

    // R6 timeout: 12 cycles after last arrival
    push_ch(8'h55);
    seen = 0;
    for (int j = 1; j <= 14; j++) begin
      cyc();
      if (tmo) seen = j;
    end
    chk("R6 timeout cycle", seen, 12);

    // R8 disabled
    lv = level;
    rx_dis = 1;
    push_ch(8'h99); rd();
    chk("R8 level held", level, lv);
    rx_dis = 0; rx_en = 0;
    push_ch(8'h98);
    chk("R8 level held en low", level, lv);
    rx_en = 1;

    // R9 flush with simultaneous arrival
    flush = 1; char_valid = 1; char_data = 8'h12; cyc(); flush = 0; char_valid = 0;
    chk("R9 empty", empty, 1);
    chk("R9 full clear", full, 0);

    // R10 break wins
    brk = 1; char_valid = 1; char_data = 8'hFF; cyc(); brk = 0; char_valid = 0;
    chk("R10 level", level, 1);
    chk("R10 zero byte", rd_data, 0);
    rd();

    // R7 modes
    mode = 1; push_ch(8'h5A);
    chk("R7 echo pushes", level, 1);
    mode = 3; push_ch(8'h6B);
    chk("R7 remote no push", level, 1);
    mode = 2;
    cpu_wr = 1; cpu_wdata = 8'h33; cyc(); cpu_wr = 0;
    chk("R7 local pushes", level, 2);
    push_ch(8'h44);
    chk("R7 local ignores line", level, 2);
    mode = 0;
    cpu_wr = 1; cpu_wdata = 8'h66; cyc(); cpu_wr = 0;
    chk("R7 normal write not queued", level, 2);
    rd(); chk("R7 local byte", rd_data, 8'h33);
    rd();
    idle(20);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule